// File: doc/BRIEF.md
# Peripheral Register Bank with Interrupt Request

This block is the software-visible register file of one peripheral on a 32-bit peripheral bus. It decodes word offsets inside a small address window and turns bus writes into one-cycle command pulses. It also holds a mode word and a 32-bit data word for the peripheral's datapath.

Two bit-vectors are kept, and both change only through shadow ports. A status vector is raised by enable writes and by the peripheral's event inputs, and is lowered by disable writes. An interrupt mask is raised and lowered the same way through its own enable and disable ports. Because of this, software never needs a read-modify-write. A registered request line is asserted whenever any status bit is set while its mask bit is set.

The byte offsets are fixed as follows. Command is 0x00 (write only), mode is 0x04, data is 0x08, status enable is 0x10, status disable is 0x14, status is 0x18 (read only), interrupt enable is 0x20, interrupt disable is 0x24, and mask is 0x28 (read only). Reads return data in the same cycle and are valid while `sel_i` is high and `wr_i` is low; otherwise `rdata_o` is zero. Writes take effect at the clock edge where `sel_i` and `wr_i` are both high.

Top module: `periph_regbank`

## Requirements
- R1: Address bits [1:0] are ignored. Any byte or half-word address reaches the enclosing 32-bit word (for example, 0x05 and 0x06 both reach mode at 0x04), and the access is a full-word access.
- R2: A write to command (0x00) drives `cmd_o` with write data bits [N_CMD-1:0] for exactly the following cycle. Zero bits produce no pulse, and `cmd_o` is zero in every other cycle.
- R3: Mode (0x04) is read/write. Its low MODE_W bits are stored, read back and driven on `mode_o`.
- R4: A write to status enable (0x10) sets every status bit whose write bit is 1. A write to status disable (0x14) clears every status bit whose write bit is 1. Bits written as 0 are unchanged.
- R5: A write to interrupt enable (0x20) sets the matching mask bits, and a write to interrupt disable (0x24) clears them. The mask reads back at 0x28.
- R6: `irq_o` equals the OR over all bits of (status AND mask), sampled one cycle earlier.
- R7: Register bits above each register's width read as 0, and writing them has no effect.
- R8: Writes to the status register (0x18) and the mask register (0x28) change nothing.
- R9: A high bit of `event_i` sets the matching status bit. If a disable write hits the same bit in the same cycle, the event wins.
- R10: Reads of command, status enable/disable, interrupt enable/disable and undecoded offsets (for example, 0x3C) return 0.
- R11: Reset clears status, mask, mode, data and command, and holds `irq_o` low.
- R12: Data (0x08) is a full 32-bit read/write register, driven on `data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access to this window |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address inside the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| event_i | input | N_STAT | Status-setting events from the peripheral |
| cmd_o | output | N_CMD | One-cycle command pulses |
| mode_o | output | MODE_W | Mode word |
| data_o | output | 32 | Data word |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench keeps a behavioural model and compares every output on every cycle. The set/clear logic is tried in three ways: with enable and disable writes that carry overlapping patterns, with single events, and with an event that lands in the same cycle as a disable write of the same bit. These three cases separate correct set/clear behaviour from plain overwrites and from the wrong priority. The mask is walked so that the request line rises and falls only when status and mask overlap, which shows the AND-then-OR and the one-cycle latency. Unaligned addresses, all-ones writes and reads of write-only or empty offsets show the address masking and the zero fill.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [3:0] {
    RG_CMD, RG_MODE, RG_DATA, RG_SSET, RG_SCLR, RG_STAT,
    RG_ISET, RG_ICLR, RG_IMSK, RG_NONE
  } reg_id_e;

  localparam int unsigned OFF_CMD  = 'h00;
  localparam int unsigned OFF_MODE = 'h04;
  localparam int unsigned OFF_DATA = 'h08;
  localparam int unsigned OFF_SSET = 'h10;
  localparam int unsigned OFF_SCLR = 'h14;
  localparam int unsigned OFF_STAT = 'h18;
  localparam int unsigned OFF_ISET = 'h20;
  localparam int unsigned OFF_ICLR = 'h24;
  localparam int unsigned OFF_IMSK = 'h28;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_id_e           id_o
);
  logic [ADDR_W-1:0] waddr;

  // sub-word accesses fold onto the enclosing word
  assign waddr = addr_i & ~ADDR_W'(3);

  always_comb begin
    unique case (waddr)
      ADDR_W'(OFF_CMD):  id_o = RG_CMD;
      ADDR_W'(OFF_MODE): id_o = RG_MODE;
      ADDR_W'(OFF_DATA): id_o = RG_DATA;
      ADDR_W'(OFF_SSET): id_o = RG_SSET;
      ADDR_W'(OFF_SCLR): id_o = RG_SCLR;
      ADDR_W'(OFF_STAT): id_o = RG_STAT;
      ADDR_W'(OFF_ISET): id_o = RG_ISET;
      ADDR_W'(OFF_ICLR): id_o = RG_ICLR;
      ADDR_W'(OFF_IMSK): id_o = RG_IMSK;
      default:           id_o = RG_NONE;
    endcase
  end
endmodule

// File: rtl/regbank_setclr.sv
module regbank_setclr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] q_o
);
  // event beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= ((q_o | set_i) & ~clr_i) | evt_i;
  end
endmodule

// File: rtl/periph_regbank.sv
module periph_regbank
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned N_CMD  = 8,
  parameter int unsigned N_STAT = 8,
  parameter int unsigned MODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_STAT-1:0] event_i,
  output logic [N_CMD-1:0]  cmd_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [31:0]       data_o,
  output logic              irq_o
);
  localparam int unsigned DW = 32;

  reg_id_e           id;
  logic              wr_en, rd_en;
  logic [N_STAT-1:0] wbits;
  logic [N_STAT-1:0] sset, sclr, iset, iclr;
  logic [N_STAT-1:0] stat_q, mask_q;

  assign wr_en = sel_i & wr_i;
  assign rd_en = sel_i & ~wr_i;
  assign wbits = wdata_i[N_STAT-1:0];

  regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .id_o   (id)
  );

  assign sset = (wr_en && id == RG_SSET) ? wbits : '0;
  assign sclr = (wr_en && id == RG_SCLR) ? wbits : '0;
  assign iset = (wr_en && id == RG_ISET) ? wbits : '0;
  assign iclr = (wr_en && id == RG_ICLR) ? wbits : '0;

  regbank_setclr #(.W(N_STAT)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sset),
    .clr_i  (sclr),
    .evt_i  (event_i),
    .q_o    (stat_q)
  );

  regbank_setclr #(.W(N_STAT)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (iset),
    .clr_i  (iclr),
    .evt_i  ({N_STAT{1'b0}}),
    .q_o    (mask_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o  <= '0;
      mode_o <= '0;
      data_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      cmd_o <= (wr_en && id == RG_CMD) ? wdata_i[N_CMD-1:0] : '0;
      if (wr_en && id == RG_MODE) mode_o <= wdata_i[MODE_W-1:0];
      if (wr_en && id == RG_DATA) data_o <= wdata_i;
      irq_o <= |(stat_q & mask_q);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      unique case (id)
        RG_MODE: rdata_o = DW'(mode_o);
        RG_DATA: rdata_o = data_o;
        RG_STAT: rdata_o = DW'(stat_q);
        RG_IMSK: rdata_o = DW'(mask_q);
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/periph_regbank_chk.sv
module periph_regbank_chk
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned N_CMD  = 8,
  parameter int unsigned N_STAT = 8,
  parameter int unsigned MODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [N_STAT-1:0] event_i,
  input logic [N_CMD-1:0]  cmd_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              irq_o,
  input logic [N_STAT-1:0] stat_q,
  input logic [N_STAT-1:0] mask_q
);
  logic [ADDR_W-1:0] wa;
  logic w_cmd, w_mode, w_sset, w_sclr, w_iset, w_iclr;
  assign wa     = {addr_i[ADDR_W-1:2], 2'b00};
  assign w_cmd  = sel_i && wr_i && wa == ADDR_W'(OFF_CMD);
  assign w_mode = sel_i && wr_i && wa == ADDR_W'(OFF_MODE);
  assign w_sset = sel_i && wr_i && wa == ADDR_W'(OFF_SSET);
  assign w_sclr = sel_i && wr_i && wa == ADDR_W'(OFF_SCLR);
  assign w_iset = sel_i && wr_i && wa == ADDR_W'(OFF_ISET);
  assign w_iclr = sel_i && wr_i && wa == ADDR_W'(OFF_ICLR);

  // R2
  cmd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !w_cmd |=> cmd_o == '0);
  // R3
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !w_mode |=> $stable(mode_o));
  // R4
  stat_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_sset |=> (stat_q & $past(wdata_i[N_STAT-1:0])) == $past(wdata_i[N_STAT-1:0]));
  // R9
  stat_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_sclr |=> (stat_q & $past(wdata_i[N_STAT-1:0]) & ~$past(event_i)) == '0);
  // R9
  evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_q & $past(event_i)) == $past(event_i));
  // R8
  stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!w_sset && !w_sclr && event_i == '0) |=> $stable(stat_q));
  // R5
  mask_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!w_iset && !w_iclr) |=> $stable(mask_q));
  // R6
  irq_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(stat_q & mask_q)));
  // R11
  rst_irq_chk: assert property (@(posedge clk_i) !rst_ni |-> !irq_o);
endmodule

bind periph_regbank periph_regbank_chk #(
  .ADDR_W(ADDR_W), .N_CMD(N_CMD), .N_STAT(N_STAT), .MODE_W(MODE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .event_i(event_i),
  .cmd_o(cmd_o), .mode_o(mode_o), .irq_o(irq_o),
  .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/sim_periph_regbank.sv
`timescale 1ns/1ps
module sim_periph_regbank;
  logic        clk = 0, rst_n = 0;
  logic        sel = 0, wr = 0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0, rdata, data_o;
  logic [7:0]  evt = '0, cmd, mode;
  logic        irq;

  int checks = 0, errors = 0;
  string tag = "R11";
  bit done = 0;

  always #2 clk = ~clk;

  periph_regbank u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .event_i(evt), .cmd_o(cmd),
    .mode_o(mode), .data_o(data_o), .irq_o(irq)
  );

  // behavioural reference
  int unsigned m_stat, m_mask, m_mode, m_data, m_cmd;
  bit m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= 0; m_mask <= 0; m_mode <= 0; m_data <= 0; m_cmd <= 0; m_irq <= 0;
    end else begin
      int unsigned a, w, s, k;
      a = int'(addr) & ~3; w = wdata;
      s = m_stat; k = m_mask;
      m_cmd <= (sel && wr && a == 'h00) ? (w & 'hFF) : 0;
      if (sel && wr && a == 'h04) m_mode <= w & 'hFF;
      if (sel && wr && a == 'h08) m_data <= w;
      if (sel && wr && a == 'h10) s = s | (w & 'hFF);
      if (sel && wr && a == 'h14) s = s & ~w;
      s = (s | int'(evt)) & 'hFF;
      if (sel && wr && a == 'h20) k = k | (w & 'hFF);
      if (sel && wr && a == 'h24) k = k & ~w & 'hFF;
      m_irq <= (m_stat & m_mask) != 0;
      m_stat <= s; m_mask <= k;
    end
  end

  function automatic int unsigned exp_rd();
    int unsigned a = int'(addr) & ~3;
    if (!(sel && !wr)) return 0;
    case (a)
      'h04: return m_mode;
      'h08: return m_data;
      'h18: return m_stat;
      'h28: return m_mask;
      default: return 0;
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (rdata !== exp_rd()) begin
      errors++; $display("FAIL %s rdata act=%h exp=%h", tag, rdata, exp_rd());
    end
    if (cmd !== m_cmd[7:0]) begin
      errors++; $display("FAIL %s cmd act=%h exp=%h", tag, cmd, m_cmd[7:0]);
    end
    if (mode !== m_mode[7:0]) begin
      errors++; $display("FAIL %s mode act=%h exp=%h", tag, mode, m_mode[7:0]);
    end
    if (data_o !== m_data) begin
      errors++; $display("FAIL %s data act=%h exp=%h", tag, data_o, m_data);
    end
    if (irq !== m_irq) begin
      errors++; $display("FAIL %s irq act=%b exp=%b", tag, irq, m_irq);
    end
  endtask

  // one bus cycle: check at negedge, then drive
  task automatic cyc(input bit s, input bit w, input int a, input logic [31:0] d,
                     input logic [7:0] e);
    @(negedge clk);
    compare();
    sel = s; wr = w; addr = 14'(a); wdata = d; evt = e;
  endtask

  task automatic wrr(input int a, input logic [31:0] d); cyc(1, 1, a, d, 0); endtask
  task automatic rdr(input int a); cyc(1, 0, a, 0, 0); endtask
  task automatic idle(); cyc(0, 0, 0, 0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11 reset values while held
    tag = "R11";
    rdr('h18); rdr('h28); rdr('h04);
    @(negedge clk); rst_n = 1;
    rdr('h18); idle();
    tag = "R2";
    wrr('h00, 32'hFFFF_FFA5); idle(); idle();
    wrr('h00, 0); idle(); idle();
    tag = "R1";
    wrr('h05, 32'h0000_003C); rdr('h06); rdr('h07); rdr('h04);
    tag = "R7";
    wrr('h04, 32'hFFFF_FFFF); rdr('h04);
    tag = "R12";
    wrr('h0A, 32'hDEAD_BEEF); rdr('h08); rdr('h09);
    tag = "R4";
    wrr('h10, 32'hFFFF_FF0F); rdr('h18);
    wrr('h14, 32'h0000_0005); rdr('h18);
    wrr('h10, 0); rdr('h18);
    tag = "R8";
    wrr('h18, 32'hFFFF_FFFF); rdr('h18);
    wrr('h28, 32'hFFFF_FFFF); rdr('h28);
    tag = "R5";
    wrr('h20, 32'h0000_00F0); rdr('h28); idle(); idle();
    tag = "R6";
    wrr('h20, 32'h0000_0002); idle(); idle(); rdr('h28);
    wrr('h24, 32'h0000_0002); idle(); idle();
    wrr('h14, 32'h0000_00FF); idle(); idle();
    tag = "R9";
    cyc(0, 0, 0, 0, 8'h40); idle(); rdr('h18); idle();
    cyc(1, 1, 'h14, 32'h0000_0040, 8'h40); rdr('h18);
    cyc(1, 1, 'h14, 32'h0000_0041, 8'h40); rdr('h18);
    wrr('h14, 32'hFF); rdr('h18); idle();
    tag = "R10";
    rdr('h00); rdr('h10); rdr('h14); rdr('h20); rdr('h24); rdr('h3C);
    tag = "R11";
    wrr('h10, 32'hFF); wrr('h20, 32'hFF); idle();
    @(negedge clk); rst_n = 0;
    rdr('h18); rdr('h28); rdr('h04); rdr('h08);
    @(negedge clk); rst_n = 1;
    idle(); idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule